// File: doc/BRIEF.md
# Power-Mode Clock Enable Gating

This block turns the chip's current power mode into per-consumer clock enables. Each clock consumer is a memory or a peripheral. It has one bus clock enable. A consumer with its own functional clock also has a kernel clock enable. Software programs two bit vectors through a small valid/address/data port. One vector applies while the core is running. The other applies while the core sleeps. Both vectors can be read back. The enables are meant to drive glitch-free clock gate cells that sit outside this block.

Consumer 0 is the flash interface. Consumers 1 and 2 are the two SRAMs. All higher indices are peripherals. A parameter mask marks which peripherals have their own kernel clock. For such a peripheral a single enable bit gates its bus clock and its kernel clock together. In the deepest supported mode (stop), every bus clock is off. A kernel-clocked peripheral can still keep its kernel clock running through its sleep-set bit.

The enables depend only on the mode and the two programmed vectors. They never depend on memory access activity. A gated flash clock is therefore never reopened by an access, and software has to avoid touching gated memories.

Top module: `cg_mode_gate`

## Requirements
- R1: While rst_ni is low, every bus and kernel enable is 0. After reset, the run set reads 0x01 (only the flash bit set) and the sleep set reads 0x07 (flash and both SRAM bits set).
- R2: In run (mode 0) and low-power run (mode 1), the bus enable of consumer i equals run-set bit i. Bits 1 and 2 (SRAMs) are forced to 1 whatever the run set holds.
- R3: In sleep (mode 2) and low-power sleep (mode 3), the bus enable of consumer i equals sleep-set bit i. The run set has no effect, and the SRAMs are not forced on.
- R4: Only consumers in the kernel mask (default bits 4..7) ever assert a kernel enable. In modes 0..3, the kernel enable of such a consumer equals its bus enable.
- R5: In stop (mode 4, and codes 5..7 treated the same), all bus enables are 0. The kernel enable of each kernel-capable consumer equals its sleep-set bit.
- R6: Software may clear the sleep-set bits of flash and the SRAMs (bits 0..2). In sleep, their bus clocks are then gated off.
- R7: A write at address 0 (run set) or address 1 (sleep set) is visible on read-back after the write edge. It reaches the enables one clock later. A mode change reaches the enables one clock after it is sampled.
- R8: Writes to addresses 2 and 3 change neither set nor any enable. Those addresses read as 0, and a read alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Power mode: 0 run, 1 low-power run, 2 sleep, 3 low-power sleep, 4..7 stop |
| reg_valid_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | 0 run set, 1 sleep set |
| reg_wdata_i | input | N_CONS | Write data, one bit per consumer |
| reg_rdata_o | output | N_CONS | Combinational read-back of the addressed set |
| bus_en_o | output | N_CONS | Registered bus clock enables |
| kern_en_o | output | N_CONS | Registered kernel clock enables |

## Verification
Read-back is due as soon as the write edge has passed. The clock enables are due one edge after that, because they are registered from the updated sets. A mode change reaches the enables after a single edge.

The bench drives inputs on falling edges. It checks read-back at the falling edge that follows the write. At that same point it also confirms that the enables still show their old values. It checks the new enables one full cycle later. The bench model uses exactly these one-edge and two-edge latencies, so an extra or missing register stage shows up as a mismatch.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_LPRUN   = 3'd1,
    PM_SLEEP   = 3'd2,
    PM_LPSLEEP = 3'd3,
    PM_STOP    = 3'd4
  } pmode_e;

  typedef enum logic [1:0] {
    CLS_RUN   = 2'd0,
    CLS_SLEEP = 2'd1,
    CLS_STOP  = 2'd2
  } mode_cls_e;

  localparam int unsigned IDX_FLASH  = 0;
  localparam int unsigned IDX_SRAM1  = 1;
  localparam int unsigned IDX_SRAM2  = 2;
  localparam int unsigned ADDR_RUN   = 0;
  localparam int unsigned ADDR_SLEEP = 1;
endpackage

// File: rtl/cg_mode_decode.sv
module cg_mode_decode
  import cg_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_cls_e  cls_o
);
  always_comb begin
    case (mode_i)
      PM_RUN, PM_LPRUN:     cls_o = CLS_RUN;
      PM_SLEEP, PM_LPSLEEP: cls_o = CLS_SLEEP;
      default:              cls_o = CLS_STOP;
    endcase
  end
endmodule

// File: rtl/cg_enable_regs.sv
module cg_enable_regs
  import cg_pkg::*;
#(
  parameter int unsigned N_CONS = 8,
  parameter int unsigned ADDR_W = 2,
  parameter logic [N_CONS-1:0] RUN_RST = '0,
  parameter logic [N_CONS-1:0] SLEEP_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_CONS-1:0] wdata_i,
  output logic [N_CONS-1:0] rdata_o,
  output logic [N_CONS-1:0] run_en_o,
  output logic [N_CONS-1:0] sleep_en_o
);
  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(ADDR_RUN);
  localparam logic [ADDR_W-1:0] A_SLEEP = ADDR_W'(ADDR_SLEEP);

  logic [N_CONS-1:0] run_q, sleep_q;
  logic              wr_run, wr_sleep;

  assign wr_run   = valid_i && we_i && (addr_i == A_RUN);
  assign wr_sleep = valid_i && we_i && (addr_i == A_SLEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= RUN_RST;
      sleep_q <= SLEEP_RST;
    end else begin
      if (wr_run)   run_q   <= wdata_i;
      if (wr_sleep) sleep_q <= wdata_i;
    end
  end

  always_comb begin
    if (addr_i == A_RUN)        rdata_o = run_q;
    else if (addr_i == A_SLEEP) rdata_o = sleep_q;
    else                        rdata_o = '0;
  end

  assign run_en_o   = run_q;
  assign sleep_en_o = sleep_q;
endmodule

// File: rtl/cg_gate_bank.sv
module cg_gate_bank
  import cg_pkg::*;
#(
  parameter int unsigned N_CONS = 8,
  parameter logic [N_CONS-1:0] FORCE_RUN = '0,
  parameter logic [N_CONS-1:0] KMASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_cls_e         cls_i,
  input  logic [N_CONS-1:0] run_en_i,
  input  logic [N_CONS-1:0] sleep_en_i,
  output logic [N_CONS-1:0] bus_en_o,
  output logic [N_CONS-1:0] kern_en_o
);
  for (genvar i = 0; i < N_CONS; i++) begin : g_cons
    logic bus_d, bus_q;

    always_comb begin
      case (cls_i)
        CLS_RUN:   bus_d = run_en_i[i] | FORCE_RUN[i];
        CLS_SLEEP: bus_d = sleep_en_i[i];
        default:   bus_d = 1'b0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bus_q <= 1'b0;
      else         bus_q <= bus_d;
    end
    assign bus_en_o[i] = bus_q;

    if (KMASK[i]) begin : g_kern
      logic kern_d, kern_q;
      // stop keeps the kernel alive on the sleep bit alone
      assign kern_d = (cls_i == CLS_STOP) ? sleep_en_i[i] : bus_d;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) kern_q <= 1'b0;
        else         kern_q <= kern_d;
      end
      assign kern_en_o[i] = kern_q;
    end else begin : g_nokern
      assign kern_en_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cg_mode_gate.sv
module cg_mode_gate
  import cg_pkg::*;
#(
  parameter int unsigned N_CONS = 8,
  parameter int unsigned ADDR_W = 2,
  parameter logic [N_CONS-1:0] KERNEL_MASK = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              reg_valid_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N_CONS-1:0] reg_wdata_i,
  output logic [N_CONS-1:0] reg_rdata_o,
  output logic [N_CONS-1:0] bus_en_o,
  output logic [N_CONS-1:0] kern_en_o
);
  localparam logic [N_CONS-1:0] ONE        = N_CONS'(1);
  localparam logic [N_CONS-1:0] FLASH_BIT  = ONE << IDX_FLASH;
  localparam logic [N_CONS-1:0] SRAM_MASK  = (ONE << IDX_SRAM1) | (ONE << IDX_SRAM2);
  localparam logic [N_CONS-1:0] MEM_MASK   = FLASH_BIT | SRAM_MASK;
  localparam logic [N_CONS-1:0] KMASK_EFF  = KERNEL_MASK & ~MEM_MASK;

  mode_cls_e         cls;
  logic [N_CONS-1:0] run_en_q, sleep_en_q;

  cg_mode_decode i_dec (
    .mode_i (mode_i),
    .cls_o  (cls)
  );

  cg_enable_regs #(
    .N_CONS    (N_CONS),
    .ADDR_W    (ADDR_W),
    .RUN_RST   (FLASH_BIT),
    .SLEEP_RST (MEM_MASK)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (reg_valid_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .run_en_o   (run_en_q),
    .sleep_en_o (sleep_en_q)
  );

  cg_gate_bank #(
    .N_CONS    (N_CONS),
    .FORCE_RUN (SRAM_MASK),
    .KMASK     (KMASK_EFF)
  ) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cls_i      (cls),
    .run_en_i   (run_en_q),
    .sleep_en_i (sleep_en_q),
    .bus_en_o   (bus_en_o),
    .kern_en_o  (kern_en_o)
  );
endmodule

// File: rtl/cg_mode_gate_chk.sv
module cg_mode_gate_chk
  import cg_pkg::*;
#(
  parameter int unsigned N_CONS = 8,
  parameter int unsigned ADDR_W = 2,
  parameter logic [N_CONS-1:0] KMASK = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic              reg_valid_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [N_CONS-1:0] reg_wdata_i,
  input logic [N_CONS-1:0] reg_rdata_o,
  input logic [N_CONS-1:0] bus_en_o,
  input logic [N_CONS-1:0] kern_en_o,
  input logic [N_CONS-1:0] sleep_en_i
);
  a_r2_sram_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) <= 3'd1)
      |-> (bus_en_o[IDX_SRAM1] && bus_en_o[IDX_SRAM2]));

  a_r3_sleep_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(mode_i) == 3'd2 || $past(mode_i) == 3'd3))
      |-> (bus_en_o == $past(sleep_en_i)));

  a_r4_kern_capable_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kern_en_o & ~KMASK) == '0);

  a_r4_kern_tracks_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) <= 3'd3) |-> (kern_en_o == (bus_en_o & KMASK)));

  a_r5_stop_bus_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) >= 3'd4) |-> (bus_en_o == '0));

  a_r5_stop_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) >= 3'd4) |-> (kern_en_o == ($past(sleep_en_i) & KMASK)));

  a_r7_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(reg_valid_i && reg_we_i && reg_addr_i == ADDR_W'(ADDR_RUN))
     && reg_addr_i == ADDR_W'(ADDR_RUN)) |-> (reg_rdata_o == $past(reg_wdata_i)));

  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i > ADDR_W'(ADDR_SLEEP)) |-> (reg_rdata_o == '0));
endmodule

bind cg_mode_gate cg_mode_gate_chk #(
  .N_CONS (N_CONS),
  .ADDR_W (ADDR_W),
  .KMASK  (KMASK_EFF)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .reg_valid_i (reg_valid_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .bus_en_o    (bus_en_o),
  .kern_en_o   (kern_en_o),
  .sleep_en_i  (sleep_en_q)
);

// File: tb/test_cg_mode_gate.sv
module test_cg_mode_gate;
  localparam int N = 8;
  localparam logic [N-1:0] KM = 8'hF0;
  localparam logic [N-1:0] SRAMS = 8'h06;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic         valid = 1'b0, we = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, bus, kern;

  int checks = 0, fails = 0;
  logic [N-1:0] m_run = 8'h01, m_sleep = 8'h07;

  always #10 clk = ~clk;

  cg_mode_gate i_cg_mode_gate (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .reg_valid_i(valid), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .bus_en_o(bus), .kern_en_o(kern)
  );

  function automatic logic [N-1:0] exp_bus(logic [2:0] m, logic [N-1:0] r, logic [N-1:0] s);
    if (m <= 3'd1) return r | SRAMS;
    if (m <= 3'd3) return s;
    return '0;
  endfunction

  function automatic logic [N-1:0] exp_kern(logic [2:0] m, logic [N-1:0] r, logic [N-1:0] s);
    if (m >= 3'd4) return s & KM;
    return exp_bus(m, r, s) & KM;
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    chk({req, " bus"}, bus, exp_bus(mode, m_run, m_sleep));
    chk({req, " kern"}, kern, exp_kern(mode, m_run, m_sleep));
  endtask

  task automatic rd(logic [1:0] a, string req, logic [N-1:0] exp);
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = a;
    #1 chk(req, rdata, exp);
  endtask

  // write, check read-back and old enables, then new enables one edge later (R7)
  task automatic wr(logic [1:0] a, logic [N-1:0] d, string req);
    logic [N-1:0] old_b, old_k;
    @(negedge clk);
    old_b = exp_bus(mode, m_run, m_sleep);
    old_k = exp_kern(mode, m_run, m_sleep);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (a == 2'd0) m_run = d;
    else if (a == 2'd1) m_sleep = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
    #1;
    chk({req, " R7 readback"}, rdata, (a <= 2'd1) ? d : '0);
    chk({req, " R7 old bus"}, bus, old_b);
    chk({req, " R7 old kern"}, kern, old_k);
    @(posedge clk);
    @(negedge clk);
    chk_out(req);
  endtask

  task automatic set_mode(logic [2:0] m, string req);
    @(negedge clk);
    mode = m;
    @(posedge clk);
    @(negedge clk);
    chk_out(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1234_5678);
    repeat (3) @(negedge clk);
    chk("R1 reset bus", bus, '0);
    chk("R1 reset kern", kern, '0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_out("R1 R2 after reset");
    rd(2'd0, "R1 run reset", 8'h01);
    rd(2'd1, "R1 sleep reset", 8'h07);

    // directed corners
    wr(2'd0, 8'h00, "R2 srams forced");
    set_mode(3'd1, "R2 lp run");
    wr(2'd0, 8'hA9, "R2 R4 run set");
    set_mode(3'd2, "R3 sleep");
    wr(2'd1, 8'h30, "R6 memories cleared");
    chk("R6 flash gated", {7'd0, bus[0]}, 8'h00);
    set_mode(3'd3, "R3 lp sleep");
    set_mode(3'd4, "R5 stop");
    wr(2'd1, 8'hC8, "R5 stop kernel");
    set_mode(3'd7, "R5 stop alias");
    wr(2'd2, 8'hFF, "R8 unmapped write 2");
    wr(2'd3, 8'h5A, "R8 unmapped write 3");
    rd(2'd2, "R8 unmapped read", 8'h00);
    rd(2'd0, "R8 run intact", m_run);
    rd(2'd1, "R8 sleep intact", m_sleep);
    set_mode(3'd0, "R4 run kernel");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom_range(0, 2);
      if (op == 0) set_mode(3'($urandom_range(0, 7)), "R2 R3 R5 rnd mode");
      else if (op == 1) wr(2'($urandom_range(0, 3)), N'($urandom), "R7 R8 rnd write");
      else begin
        logic [1:0] a;
        a = 2'($urandom_range(0, 3));
        rd(a, "R8 rnd read", (a == 2'd0) ? m_run : (a == 2'd1) ? m_sleep : '0);
        @(posedge clk);
        @(negedge clk);
        chk_out("R4 rnd read no effect");
      end
    end
    valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule